// File: doc/BRIEF.md
# Flash Bulk Erase Sequencer

This block is a host-side controller that wipes every byte of a command-register flash memory attached to a byte-wide parallel bus. On a start request it raises the programming-voltage enable and lets the supply settle. It then repeats a loop: issue a timed erase pulse, then read back bytes in verify mode, one at a time. A byte that reads all ones moves the sweep to the next address. A byte that still holds zeros triggers another erase pulse, and the sweep then resumes at that same byte. Bytes that already passed are not read again.

Each bus access is a fixed-width strobe window. The controller drives chip enable together with either write enable or output enable. It drives the data lines only during writes, and it holds them for one cycle after write enable rises. The long settling delays are counted in clock cycles. Their lengths are parameters, so one build can target any clock rate. When the sweep reaches the last address, or when the pulse budget runs out on a stubborn byte, the controller returns the device to read mode and drops the programming voltage. It then reports done, fail and the address where it stopped.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the chip-enable, write-enable and output-enable strobes are high (inactive), the data lines are not driven, and the voltage enable, busy, done and fail outputs are all 0.
- R2: A start request taken in idle sets busy and the voltage enable, and clears done and fail. No bus write begins until at least RAMP_CYC cycles later. Write enable is never low while the voltage enable is 0.
- R3: Each erase pulse consists of two consecutive bus writes of data 20h: a setup write followed by the erase write.
- R4: After the erase write, the verify command A0h is written on the data lines no earlier than ERASE_CYC cycles later. The address of the byte under test is on the address lines during that write.
- R5: The verify read begins no earlier than VFY_CYC cycles after the verify command write. A read of FFh advances to the next address. Any other value starts a new erase pulse.
- R6: After an extra erase pulse, verification resumes at the byte that failed. The address sequence never goes back to zero within one run.
- R7: When the last address (latched from last_addr_i at start) reads FFh, the controller writes FFh. It then drops the voltage enable and ends with done=1, fail=0, busy=0.
- R8: If a byte still fails after MAX_PULSES pulses, no further pulse is issued. The controller writes FFh, drops the voltage enable, and ends with done=1, fail=1 and fail_addr_o equal to that byte's address.
- R9: A start request while busy has no effect. This includes a changed last_addr_i value.
- R10: A write cycle holds chip enable and write enable low for STB_CYC cycles with the data lines driven. A read cycle holds chip enable and output enable low with the data lines released. Write enable and output enable are never low together.
- R11: done, fail and fail_addr_o keep their values until the next accepted start, and that start clears done and fail on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Erase request, taken only when idle |
| last_addr_i | input | ADDR_W | Highest byte address to erase |
| flash_ce_n_o | output | 1 | Chip enable strobe, active low |
| flash_we_n_o | output | 1 | Write enable strobe, active low |
| flash_oe_n_o | output | 1 | Output enable strobe, active low |
| flash_addr_o | output | ADDR_W | Byte address to the flash |
| flash_dq_o | output | DATA_W | Write data / command to the flash |
| flash_dq_oe_o | output | 1 | Drive enable for the data lines |
| flash_dq_i | input | DATA_W | Read data from the flash |
| vpp_en_o | output | 1 | Programming-voltage enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (sticky until next start) |
| fail_o | output | 1 | Pulse budget exhausted (sticky until next start) |
| fail_addr_o | output | ADDR_W | Address where a failed sequence stopped |

## Verification
Busy goes high and done and fail clear one clock after the edge that takes a start, so the bench samples them at the next falling edge. The delays cannot be exact, because each request passes through a registered bus stage and a registered timer. For that reason the ramp, erase and verify waits are checked as lower bounds. The ramp wait is measured from start to the first falling write enable. The erase wait is measured from the rising write enable of the erase write to that of the next verify command. The verify wait is measured from the verify command to the falling output enable. The expected sequence of verify addresses is computed from a per-byte model of how many pulses each byte needs. The bench checks it in order as each verify command leaves the block. It checks the final status only once done has risen.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_RAMP,
    SQ_SETUP,
    SQ_ERASE,
    SQ_PULSE,
    SQ_VCMD,
    SQ_VWAIT,
    SQ_VREAD,
    SQ_RESET,
    SQ_FINISH
  } seq_state_t;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_STROBE,
    BS_HOLD
  } bus_state_t;

endpackage

// File: rtl/fes_delay_timer.sv
module fes_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] remain_q;
  logic             run_q;

  // expired_o pulses once, len_i cycles after go_i is sampled (len_i >= 1)
  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q  <= '0;
      run_q     <= 1'b0;
      expired_o <= 1'b0;
    end else if (go_i) begin
      remain_q  <= len_i;
      run_q     <= 1'b1;
      expired_o <= 1'b0;
    end else if (run_q) begin
      if (remain_q <= CNT_W'(1)) begin
        run_q     <= 1'b0;
        expired_o <= 1'b1;
      end else begin
        remain_q  <= remain_q - CNT_W'(1);
        expired_o <= 1'b0;
      end
    end else begin
      expired_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fes_bus_cycle.sv
module fes_bus_cycle
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int STB_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);

  localparam int SW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;

  bus_state_t     st_q;
  logic [SW-1:0]  cnt_q;
  logic           rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= BS_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      addr_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      unique case (st_q)
        BS_IDLE: begin
          if (req_i) begin
            addr_o <= addr_i;
            dq_o   <= data_i;
            rd_q   <= rd_i;
            ce_n_o <= 1'b0;
            cnt_q  <= SW'(STB_CYC - 1);
            if (rd_i) begin
              oe_n_o <= 1'b0;
            end else begin
              we_n_o  <= 1'b0;
              dq_oe_o <= 1'b1;
            end
            st_q <= BS_STROBE;
          end
        end
        BS_STROBE: begin
          if (cnt_q == '0) begin
            if (rd_q) rdata_o <= dq_i;
            ce_n_o <= 1'b1;
            we_n_o <= 1'b1;
            oe_n_o <= 1'b1;
            st_q   <= BS_HOLD;
          end else begin
            cnt_q <= cnt_q - SW'(1);
          end
        end
        BS_HOLD: begin
          // data held one cycle past the rising write strobe
          dq_oe_o <= 1'b0;
          ack_o   <= 1'b1;
          st_q    <= BS_IDLE;
        end
        default: st_q <= BS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fes_sequencer.sv
module fes_sequencer
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 20,
  parameter int RAMP_CYC   = 100,
  parameter int ERASE_CYC  = 1000,
  parameter int VFY_CYC    = 10,
  parameter int MAX_PULSES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic              bus_req_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              tmr_go_o,
  output logic [CNT_W-1:0]  tmr_len_o,
  input  logic              tmr_exp_i,
  output logic              vpp_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);

  localparam int PW = $clog2(MAX_PULSES + 1);

  seq_state_t        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  logic [PW-1:0]     pulses_q;
  logic              launched_q;
  logic              fail_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      addr_q      <= '0;
      last_q      <= '0;
      pulses_q    <= '0;
      launched_q  <= 1'b0;
      fail_pend_q <= 1'b0;
      bus_req_o   <= 1'b0;
      bus_rd_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_data_o  <= '0;
      tmr_go_o    <= 1'b0;
      tmr_len_o   <= '0;
      vpp_en_o    <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
    end else begin
      bus_req_o <= 1'b0;
      tmr_go_o  <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            addr_q      <= '0;
            pulses_q    <= '0;
            last_q      <= last_addr_i;
            fail_pend_q <= 1'b0;
            launched_q  <= 1'b0;
            vpp_en_o    <= 1'b1;
            busy_o      <= 1'b1;
            done_o      <= 1'b0;
            fail_o      <= 1'b0;
            tmr_go_o    <= 1'b1;
            tmr_len_o   <= CNT_W'(RAMP_CYC);
            st_q        <= SQ_RAMP;
          end
        end
        SQ_RAMP: if (tmr_exp_i) st_q <= SQ_SETUP;
        SQ_SETUP, SQ_ERASE, SQ_VCMD, SQ_VREAD, SQ_RESET: begin
          if (!launched_q) begin
            launched_q <= 1'b1;
            bus_req_o  <= 1'b1;
            bus_rd_o   <= (st_q == SQ_VREAD);
            bus_addr_o <= (st_q == SQ_VCMD || st_q == SQ_VREAD) ? addr_q : '0;
            bus_data_o <= (st_q == SQ_VCMD)  ? CMD_VERIFY :
                          (st_q == SQ_RESET) ? CMD_RESET  : CMD_ERASE;
          end else if (bus_ack_i) begin
            launched_q <= 1'b0;
            case (st_q)
              SQ_SETUP: st_q <= SQ_ERASE;
              SQ_ERASE: begin
                pulses_q  <= pulses_q + PW'(1);
                tmr_go_o  <= 1'b1;
                tmr_len_o <= CNT_W'(ERASE_CYC);
                st_q      <= SQ_PULSE;
              end
              SQ_VCMD: begin
                tmr_go_o  <= 1'b1;
                tmr_len_o <= CNT_W'(VFY_CYC);
                st_q      <= SQ_VWAIT;
              end
              SQ_VREAD: begin
                if (bus_rdata_i == BLANK_BYTE) begin
                  if (addr_q == last_q) begin
                    st_q <= SQ_RESET;
                  end else begin
                    addr_q <= addr_q + ADDR_W'(1);
                    st_q   <= SQ_VCMD;
                  end
                end else if (pulses_q >= PW'(MAX_PULSES)) begin
                  fail_pend_q <= 1'b1;
                  st_q        <= SQ_RESET;
                end else begin
                  st_q <= SQ_SETUP;
                end
              end
              default: begin
                vpp_en_o <= 1'b0;
                st_q     <= SQ_FINISH;
              end
            endcase
          end
        end
        SQ_PULSE: if (tmr_exp_i) st_q <= SQ_VCMD;
        SQ_VWAIT: if (tmr_exp_i) st_q <= SQ_VREAD;
        SQ_FINISH: begin
          busy_o      <= 1'b0;
          done_o      <= 1'b1;
          fail_o      <= fail_pend_q;
          fail_addr_o <= addr_q;
          st_q        <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STB_CYC    = 4,
  parameter int RAMP_CYC   = 50000,
  parameter int ERASE_CYC  = 500000,
  parameter int VFY_CYC    = 300,
  parameter int MAX_PULSES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic              flash_ce_n_o,
  output logic              flash_we_n_o,
  output logic              flash_oe_n_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              vpp_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);

  localparam int MAX_A = (RAMP_CYC > ERASE_CYC) ? RAMP_CYC : ERASE_CYC;
  localparam int MAX_D = (MAX_A > VFY_CYC) ? MAX_A : VFY_CYC;
  localparam int CNT_W = $clog2(MAX_D + 1);

  logic              bus_req, bus_rd, bus_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data, bus_rdata;
  logic              tmr_go, tmr_exp;
  logic [CNT_W-1:0]  tmr_len;

  fes_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RAMP_CYC(RAMP_CYC), .ERASE_CYC(ERASE_CYC),
    .VFY_CYC(VFY_CYC), .MAX_PULSES(MAX_PULSES)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .last_addr_i(last_addr_i),
    .bus_req_o(bus_req), .bus_rd_o(bus_rd), .bus_addr_o(bus_addr),
    .bus_data_o(bus_data), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .tmr_go_o(tmr_go), .tmr_len_o(tmr_len), .tmr_exp_i(tmr_exp),
    .vpp_en_o(vpp_en_o), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .fail_addr_o(fail_addr_o)
  );

  fes_bus_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_CYC(STB_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .req_i(bus_req), .rd_i(bus_rd),
    .addr_i(bus_addr), .data_i(bus_data), .ack_o(bus_ack),
    .rdata_o(bus_rdata), .ce_n_o(flash_ce_n_o), .we_n_o(flash_we_n_o),
    .oe_n_o(flash_oe_n_o), .addr_o(flash_addr_o), .dq_o(flash_dq_o),
    .dq_oe_o(flash_dq_oe_o), .dq_i(flash_dq_i)
  );

  fes_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .go_i(tmr_go), .len_i(tmr_len), .expired_o(tmr_exp)
  );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [ADDR_W-1:0] last_addr_i,
  input logic              flash_ce_n_o,
  input logic              flash_we_n_o,
  input logic              flash_oe_n_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [DATA_W-1:0] flash_dq_o,
  input logic              flash_dq_oe_o,
  input logic [DATA_W-1:0] flash_dq_i,
  input logic              vpp_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o
);

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!flash_we_n_o && !flash_oe_n_o));

  a_r10_write_drives_bus: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n_o |-> (flash_dq_oe_o && !flash_ce_n_o));

  a_r10_read_releases_bus: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n_o |-> !flash_dq_oe_o);

  a_r2_write_needs_vpp: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n_o |-> vpp_en_o);

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (flash_ce_n_o && !vpp_en_o));

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  a_r11_fail_addr_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> $stable(fail_addr_o));

  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> done_o);

  a_r7_vpp_off_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (!vpp_en_o && !busy_o));

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int STB   = 3;
  localparam int RAMP  = 12;
  localparam int ERASE = 40;
  localparam int VFY   = 6;
  localparam int MAXP  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] last = '0;
  logic          ce_n, we_n, oe_n, dq_oe, vpp, busy, done, fail;
  logic [AW-1:0] faddr, fail_addr;
  logic [DW-1:0] dq_out, dq_in;

  always #5 clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(AW), .DATA_W(DW), .STB_CYC(STB), .RAMP_CYC(RAMP),
    .ERASE_CYC(ERASE), .VFY_CYC(VFY), .MAX_PULSES(MAXP)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start), .last_addr_i(last),
    .flash_ce_n_o(ce_n), .flash_we_n_o(we_n), .flash_oe_n_o(oe_n),
    .flash_addr_o(faddr), .flash_dq_o(dq_out), .flash_dq_oe_o(dq_oe),
    .flash_dq_i(dq_in), .vpp_en_o(vpp), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_addr_o(fail_addr)
  );

  // flash model: byte a reads FFh once need[a] pulses have been applied
  int need [16];
  int pulses;
  assign dq_in = (!ce_n && !oe_n) ? ((pulses >= need[faddr]) ? 8'hFF : 8'h00) : 8'h5A;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int start_cyc, erase_cyc, vcmd_cyc;
  bit first_wr, gap_due;
  logic [7:0] last_cmd;
  logic prev_we = 1'b1;
  logic prev_oe = 1'b1;
  int exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    finish_run();
  end

  // monitor: pops expected verify addresses as verify commands appear
  always @(negedge clk) begin
    if (prev_we && !we_n && first_wr) begin
      first_wr = 0;
      chk(cyc - start_cyc >= RAMP, "R2 ramp wait", cyc - start_cyc, RAMP);
    end
    if (!prev_we && we_n) begin
      chk(dq_oe == 1'b1, "R10 data held at write end", int'(dq_oe), 1);
      if (dq_out == 8'h20) begin
        if (last_cmd == 8'h20) begin
          pulses++;
          erase_cyc = cyc;
          gap_due = 1;
          last_cmd = 8'h00;
        end else last_cmd = 8'h20;
      end else begin
        if (dq_out == 8'hA0) begin
          if (exp_q.size() == 0) begin
            chk(0, "R6 unexpected verify", int'(faddr), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(faddr) == e, "R4/R6 verify address", int'(faddr), e);
          end
          if (gap_due) chk(cyc - erase_cyc >= ERASE, "R4 erase wait", cyc - erase_cyc, ERASE);
          gap_due = 0;
          vcmd_cyc = cyc;
        end else if (last_cmd == 8'h20) begin
          chk(0, "R3 setup not followed by erase", int'(dq_out), 32);
        end
        last_cmd = dq_out;
      end
    end
    if (prev_oe && !oe_n)
      chk(cyc - vcmd_cyc >= VFY, "R5 verify wait", cyc - vcmd_cyc, VFY);
    prev_we = we_n;
    prev_oe = oe_n;
  end

  // driver: computes expected verify order and final status, runs one erase
  task automatic run_case(string name, int lst, bit poke);
    int p, a, fa;
    bit f;
    p = 1; a = 0; f = 0; fa = 0;
    forever begin
      exp_q.push_back(a);
      if (need[a] <= p) begin
        if (a == lst) break;
        a++;
      end else if (p == MAXP) begin
        f = 1; fa = a; break;
      end else p++;
    end
    pulses = 0;
    first_wr = 1;
    gap_due = 0;
    last_cmd = 8'h00;
    @(negedge clk);
    last = AW'(lst);
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(vpp == 1'b1, "R2 vpp after start", int'(vpp), 1);
    chk(done == 1'b0 && fail == 1'b0, "R11 start clears status", int'({done, fail}), 0);
    if (poke) begin
      repeat (80) @(negedge clk);
      last = AW'(2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 start while busy", int'(busy), 1);
    end
    while (!done) @(negedge clk);
    $display("  case %s finished", name);
    chk(fail == f, "R7/R8 fail flag", int'(fail), int'(f));
    if (f) chk(int'(fail_addr) == fa, "R8 fail address", int'(fail_addr), fa);
    chk(pulses == p, "R8 pulse count", pulses, p);
    chk(vpp == 1'b0 && busy == 1'b0, "R7 vpp and busy low", int'({vpp, busy}), 0);
    chk(last_cmd == 8'hFF, "R7 reset command last", int'(last_cmd), 255);
    chk(exp_q.size() == 0, "R6 all verifies seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) need[i] = 1;
    pulses = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ce_n && we_n && oe_n, "R1 strobes high", int'({ce_n, we_n, oe_n}), 7);
    chk(dq_oe == 1'b0 && vpp == 1'b0, "R1 bus and vpp off", int'({dq_oe, vpp}), 0);
    chk(!busy && !done && !fail, "R1 status clear", int'({busy, done, fail}), 0);

    // every byte clears after one pulse, full array
    run_case("single pulse", 15, 0);
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && fail == 1'b0, "R11 status holds", int'({done, fail}), 2);

    // stubborn bytes: resume at failing byte; a start while busy is ignored
    need[3] = 3; need[7] = 2;
    run_case("resume", 9, 1);

    // budget exhausted at byte 5
    for (int i = 0; i < 16; i++) need[i] = 1;
    need[5] = 6;
    run_case("fail", 15, 0);
    repeat (10) @(negedge clk);
    chk(fail == 1'b1 && int'(fail_addr) == 5, "R11 fail holds", int'(fail_addr), 5);

    // single-byte array, two pulses needed; start clears sticky fail
    for (int i = 0; i < 16; i++) need[i] = 1;
    need[0] = 2;
    run_case("last zero", 0, 0);

    finish_run();
  end

endmodule